// File: doc/BRIEF.md
# Sliding-Window Waveform Match Trigger

This block watches a stream of unsigned 12-bit ADC samples and fires a trigger when the shape of the most recent 32 samples is close enough to a stored reference shape. Every accepted sample enters a 32-deep history window. The block then forms the sum of absolute differences between that window and the reference, position by position, and compares the sum with a programmable threshold. Samples arrive at the full capture rate with no decimation.

Software loads the 32 reference entries and the threshold through a small write port. It then pulses the arm input. Once 32 samples have been accepted since arming, each new window is judged. The first window whose sum is strictly below the threshold produces a one-cycle trigger pulse. The block then stays disarmed until it is armed again. The sum is formed in a fully registered adder tree, so the delay from sample to trigger is fixed.

Top module: `sad_trigger`

## Requirements
- R1: The history window advances only on cycles with `smp_vld_i` high. The value on `smp_i` in cycles with `smp_vld_i` low has no effect on any later trigger decision.
- R2: After every accepted sample the block computes the sum over k = 0..31 of |window[k] - reference[k]|. Here window[0] is the oldest and window[31] the newest of the last 32 accepted samples, and reference[k] is the entry written at address k.
- R3: A window triggers only when its sum is strictly less than the threshold. A sum equal to the threshold does not trigger.
- R4: The sum is 17 bits wide and never wraps. With all 32 differences at full scale (sum 131040), a threshold of 131041 triggers and a threshold of 131040 does not.
- R5: No trigger occurs until 32 samples have been accepted since the last arm. A sample accepted in the same cycle as the arm counts as the first of the 32.
- R6: When the sample that completes a matching window is accepted on clock edge E, `trig_o` is high for the cycle that follows the seventh rising edge after E.
- R7: `trig_o` is a single-cycle pulse. After it fires, the block stays disarmed and produces no further pulse until `arm_i` is pulsed again.
- R8: A cycle with `arm_i` high discards every window still in flight, and `trig_o` is low in the cycle after it. The block is armed from that cycle on.
- R9: With `cfg_we_i` high, address 0..31 writes reference entry `cfg_addr_i` from bits 11:0 of `cfg_wdata_i`, and address 32 writes the 17-bit threshold. Addresses 33..63 change nothing.
- R10: After reset `trig_o` is low and the block is disarmed. The threshold, the reference and the window are all zero, and the accepted-sample count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse: restarts the sample count and flushes in-flight windows |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 12 | Unsigned sample |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | 0..31 reference entry, 32 threshold |
| cfg_wdata_i | input | 17 | Write data |
| trig_o | output | 1 | Trigger pulse |

## Verification
Two events can land on the same clock edge: an arm request, and a matching window leaving the pipeline or a sample being accepted. The bench provokes the first case by re-arming a few cycles after a match has entered the pipeline, so that the match would otherwise surface. It expects no pulse and checks that a fresh 32-sample fill is needed. It provokes the second case by driving `arm_i` and `smp_vld_i` together and expects the trigger after only 31 further samples. A cycle-level reference model in the bench, with a queue that mirrors the fixed latency, predicts `trig_o` on every cycle, including under random arming.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned SAD_SAMPLE_W = 12;
  localparam int unsigned SAD_WIN      = 32;

  typedef struct packed {
    logic vld;
    logic full;
  } sad_tag_t;
endpackage

// File: rtl/sad_window.sv
module sad_window
  import sad_pkg::*;
#(
  parameter int unsigned W     = 12,
  parameter int unsigned WIN   = 32,
  parameter int unsigned CNT_W = $clog2(WIN + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      arm_i,
  input  logic                      vld_i,
  input  logic [W-1:0]              smp_i,
  output logic [WIN-1:0][W-1:0]     win_o,
  output logic [CNT_W-1:0]          fill_o,
  output sad_tag_t                  tag_o
);
  logic [WIN-1:0][W-1:0] win_q;
  logic [CNT_W-1:0]      fill_q, fill_d;
  sad_tag_t              tag_q;

  // count of accepted samples since arm, saturating at WIN
  always_comb begin
    fill_d = fill_q;
    if (arm_i)                                     fill_d = vld_i ? CNT_W'(1) : '0;
    else if (vld_i && (fill_q != CNT_W'(WIN)))     fill_d = fill_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
      tag_q  <= '0;
    end else begin
      if (vld_i) begin
        for (int i = 0; i < WIN - 1; i++) win_q[i] <= win_q[i+1];
        win_q[WIN-1] <= smp_i;
      end
      fill_q    <= fill_d;
      tag_q.vld <= vld_i;
      tag_q.full <= (fill_d == CNT_W'(WIN));
    end
  end

  assign win_o  = win_q;
  assign fill_o = fill_q;
  assign tag_o  = tag_q;
endmodule

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int unsigned W     = 12,
  parameter int unsigned WIN   = 32,
  parameter int unsigned IDX_W = $clog2(WIN)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pat_we_i,
  input  logic [IDX_W-1:0]      pat_idx_i,
  input  logic [W-1:0]          pat_data_i,
  input  logic [WIN-1:0][W-1:0] win_i,
  output logic [WIN-1:0][W-1:0] diff_o
);
  logic [WIN-1:0][W-1:0] pat_q;
  logic [WIN-1:0][W-1:0] diff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      diff_q <= '0;
    end else begin
      for (int k = 0; k < WIN; k++) begin
        if (pat_we_i && (pat_idx_i == IDX_W'(k))) pat_q[k] <= pat_data_i;
        diff_q[k] <= (win_i[k] >= pat_q[k]) ? (win_i[k] - pat_q[k])
                                            : (pat_q[k] - win_i[k]);
      end
    end
  end

  assign diff_o = diff_q;
endmodule

// File: rtl/sad_tree.sv
module sad_tree #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned N      = 32,
  parameter int unsigned LEVELS = $clog2(N),
  parameter int unsigned OUT_W  = IN_W + LEVELS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N-1:0][IN_W-1:0] d_i,
  output logic [OUT_W-1:0]       sum_o
);
  // one register stage per level; each level halves the count, widens by 1
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned LW = IN_W + l;
    localparam int unsigned LN = N >> l;
    logic [LN-1:0][LW-1:0] s;
    if (l == 0) begin : g_in
      assign s = d_i;
    end else begin : g_add
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s <= '0;
        else begin
          for (int k = 0; k < LN; k++)
            s[k] <= LW'(g_lvl[l-1].s[2*k]) + LW'(g_lvl[l-1].s[2*k+1]);
        end
      end
    end
  end

  assign sum_o = g_lvl[LEVELS].s[0];
endmodule

// File: rtl/sad_trigger.sv
module sad_trigger
  import sad_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAD_SAMPLE_W,
  parameter int unsigned WIN      = SAD_WIN,
  localparam int unsigned LVL     = $clog2(WIN),
  localparam int unsigned SUM_W   = SAMPLE_W + LVL,
  localparam int unsigned ADDR_W  = LVL + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                smp_vld_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [SUM_W-1:0]    cfg_wdata_i,
  output logic                trig_o
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam int unsigned DEPTH = LVL + 1;   // diff stage + tree levels

  logic [WIN-1:0][SAMPLE_W-1:0] win;
  logic [WIN-1:0][SAMPLE_W-1:0] diff;
  logic [CNT_W-1:0]             fill_cnt;
  logic [SUM_W-1:0]             tree_sum;
  logic [SUM_W-1:0]             thr_q;
  sad_tag_t                     tag0;
  sad_tag_t                     tag_q [DEPTH];
  logic                         armed_q, trig_q, fire, last_vld;
  logic                         pat_we, thr_we;

  assign pat_we = cfg_we_i && !cfg_addr_i[ADDR_W-1];
  assign thr_we = cfg_we_i && (cfg_addr_i == ADDR_W'(WIN));

  sad_window #(.W(SAMPLE_W), .WIN(WIN), .CNT_W(CNT_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_i),
    .vld_i  (smp_vld_i),
    .smp_i  (smp_i),
    .win_o  (win),
    .fill_o (fill_cnt),
    .tag_o  (tag0)
  );

  sad_absdiff #(.W(SAMPLE_W), .WIN(WIN), .IDX_W(LVL)) u_diff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pat_we_i   (pat_we),
    .pat_idx_i  (cfg_addr_i[LVL-1:0]),
    .pat_data_i (cfg_wdata_i[SAMPLE_W-1:0]),
    .win_i      (win),
    .diff_o     (diff)
  );

  sad_tree #(.IN_W(SAMPLE_W), .N(WIN), .LEVELS(LVL), .OUT_W(SUM_W)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (diff),
    .sum_o  (tree_sum)
  );

  // tag pipeline tracks the data path; arm flushes everything past the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else begin
      tag_q[0] <= arm_i ? '0 : tag0;
      for (int i = 1; i < DEPTH; i++) tag_q[i] <= arm_i ? '0 : tag_q[i-1];
    end
  end

  assign last_vld = tag_q[DEPTH-1].vld;
  assign fire     = !arm_i && armed_q && last_vld && tag_q[DEPTH-1].full &&
                    (tree_sum < thr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q   <= '0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      if (thr_we) thr_q <= cfg_wdata_i;
      if (arm_i)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
      trig_q <= fire;
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/sad_trigger_chk.sv
module sad_trigger_chk #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned WIN      = 32,
  localparam int unsigned LVL     = $clog2(WIN),
  localparam int unsigned SUM_W   = SAMPLE_W + LVL,
  localparam int unsigned CNT_W   = $clog2(WIN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             trig_o,
  input logic             armed_i,
  input logic [CNT_W-1:0] fill_i,
  input logic [SUM_W-1:0] sum_i,
  input logic [SUM_W-1:0] thr_i,
  input logic             last_vld_i
);
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(WIN * ((1 << SAMPLE_W) - 1));

  p_below_thr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(sum_i) < $past(thr_i)));

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_i <= SUM_MAX);

  p_full_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (fill_i == CNT_W'(WIN)));

  p_from_pipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(last_vld_i));

  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_disarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !armed_i);

  p_arm_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!trig_o && armed_i));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r10: assert (!trig_o && !armed_i && (thr_i == '0));
    end
  end
endmodule

bind sad_trigger sad_trigger_chk #(.SAMPLE_W(SAMPLE_W), .WIN(WIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arm_i      (arm_i),
  .trig_o     (trig_o),
  .armed_i    (armed_q),
  .fill_i     (fill_cnt),
  .sum_i      (tree_sum),
  .thr_i      (thr_q),
  .last_vld_i (last_vld)
);

// File: tb/sad_trigger_bench.sv
module sad_trigger_bench;
  localparam int W   = 12;
  localparam int WIN = 32;
  localparam int D   = 7;   // pipeline stages ahead of the trigger register

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0, smp_vld_i = 1'b0, cfg_we_i = 1'b0;
  logic [11:0] smp_i = '0;
  logic [5:0]  cfg_addr_i = '0;
  logic [16:0] cfg_wdata_i = '0;
  logic        trig_o;

  always #5 clk = ~clk;

  sad_trigger u_sad_trigger (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .smp_vld_i(smp_vld_i),
    .smp_i(smp_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .trig_o(trig_o)
  );

  int    errors = 0, checks = 0, pulses = 0;
  string phase = "R10";
  logic  obs_trig;

  // reference model
  int m_win [WIN];
  int m_pat [WIN];
  int m_thr = 0, m_fill = 0;
  bit m_armed = 0, exp_trig = 0;
  bit pv [D];
  bit pf [D];
  int ps [D];

  initial begin
    for (int i = 0; i < WIN; i++) begin m_win[i] = 0; m_pat[i] = 0; end
    for (int i = 0; i < D; i++) begin pv[i] = 0; pf[i] = 0; ps[i] = 0; end
  end

  function automatic int model_sad();
    int s = 0;
    for (int k = 0; k < WIN; k++)
      s += (m_win[k] >= m_pat[k]) ? m_win[k] - m_pat[k] : m_pat[k] - m_win[k];
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit arm, input bit vld, input int smp,
                      input bit we = 0, input int addr = 0, input int wd = 0);
    bit nt;
    @(negedge clk);
    obs_trig = trig_o;
    chk(trig_o === exp_trig, phase, int'(trig_o), int'(exp_trig));
    if (trig_o === 1'b1) pulses++;
    arm_i = arm; smp_vld_i = vld; smp_i = 12'(smp);
    cfg_we_i = we; cfg_addr_i = 6'(addr); cfg_wdata_i = 17'(wd);
    nt = !arm && m_armed && pv[D-1] && pf[D-1] && (ps[D-1] < m_thr);
    for (int i = D - 1; i > 0; i--) begin
      pv[i] = arm ? 1'b0 : pv[i-1];
      pf[i] = pf[i-1];
      ps[i] = ps[i-1];
    end
    if (we && addr < WIN) m_pat[addr] = wd & 12'hfff;
    if (we && addr == WIN) m_thr = wd;
    if (vld) begin
      for (int i = 0; i < WIN - 1; i++) m_win[i] = m_win[i+1];
      m_win[WIN-1] = smp;
    end
    if (arm) m_fill = vld ? 1 : 0;
    else if (vld && m_fill != WIN) m_fill++;
    pv[0] = vld;
    pf[0] = (m_fill == WIN);
    ps[0] = model_sad();
    m_armed = arm ? 1'b1 : (nt ? 1'b0 : m_armed);
    exp_trig = nt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic wr(input int addr, input int d);
    step(0, 0, 0, 1, addr, d);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'h5ad7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(trig_o === 1'b0, "R10 trig during reset", int'(trig_o), 0);
    rst_ni = 1'b1;

    // R10: default threshold zero never fires even on a perfect zero match
    phase = "R10";
    step(1, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 1, 0);
    pulses = 0; idle(10);
    chk(pulses == 0, "R10 zero threshold", pulses, 0);

    // R3: equal to threshold does not fire, one below does
    phase = "R3";
    for (int i = 0; i < WIN; i++) wr(i, i * 100);
    wr(WIN, 5);
    idle(10);
    pulses = 0;
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, i * 100 + ((i == 31) ? 5 : 0));
    idle(10);
    chk(pulses == 0, "R3 sum equal threshold", pulses, 0);
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, i * 100 + ((i == 31) ? 4 : 0));
    idle(10);
    chk(pulses == 1, "R3 sum below threshold", pulses, 1);

    // R5 and R6: need 32 samples since arm, fixed latency
    phase = "R5";
    for (int i = 0; i < WIN; i++) wr(i, 500);
    wr(WIN, 10);
    idle(10);
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, 500);
    idle(10);
    pulses = 0;
    step(1, 0, 0);
    for (int i = 0; i < WIN - 1; i++) step(0, 1, 500);
    idle(10);
    chk(pulses == 0, "R5 only 31 samples", pulses, 0);
    phase = "R6";
    step(0, 1, 500);
    lat = -1;
    for (int j = 1; j <= 12; j++) begin
      step(0, 0, 0);
      if (obs_trig === 1'b1 && lat < 0) lat = j - 1;
    end
    chk(lat == 7, "R6 edges from sample to trigger", lat, 7);

    // R7: stays disarmed after firing until re-armed
    phase = "R7";
    pulses = 0;
    for (int i = 0; i < 40; i++) step(0, 1, 500);
    idle(10);
    chk(pulses == 0, "R7 no pulse while disarmed", pulses, 0);
    step(1, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 1, 500);
    idle(10);
    chk(pulses == 1, "R7 one pulse after re-arm", pulses, 1);

    // R8: arm cancels an in-flight match; arm with a sample counts it
    phase = "R8";
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, 500);
    idle(3);
    pulses = 0;
    step(1, 0, 0);
    idle(12);
    chk(pulses == 0, "R8 arm flushes pending match", pulses, 0);
    step(1, 1, 500);
    for (int i = 0; i < WIN - 1; i++) step(0, 1, 500);
    idle(10);
    chk(pulses == 1, "R8 sample on arm cycle counts", pulses, 1);

    // R4: full-scale sum is exact
    phase = "R4";
    for (int i = 0; i < WIN; i++) wr(i, 0);
    wr(WIN, 131041);
    idle(10);
    pulses = 0;
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, 4095);
    idle(10);
    chk(pulses == 1, "R4 full scale below 131041", pulses, 1);
    wr(WIN, 131040);
    idle(2);
    pulses = 0;
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, 4095);
    idle(10);
    chk(pulses == 0, "R4 full scale equals 131040", pulses, 0);

    // R1: gaps carry garbage on smp_i that must be ignored
    phase = "R1";
    for (int i = 0; i < WIN; i++) wr(i, 100 + i * 120);
    wr(WIN, 1);
    idle(10);
    pulses = 0;
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) begin
      step(0, 1, 100 + i * 120);
      step(0, 0, $urandom_range(4095));
      step(0, 0, $urandom_range(4095));
    end
    idle(10);
    chk(pulses == 1, "R1 gaps ignored", pulses, 1);

    // R9: out-of-map writes change neither threshold nor reference
    phase = "R9";
    wr(WIN, 200);
    wr(45, 0);
    wr(63, 0);
    wr(33, 0);
    idle(10);
    pulses = 0;
    step(1, 0, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, 100 + i * 120 + ((i % 4 == 0) ? 3 : 0));
    idle(10);
    chk(pulses == 1, "R9 unmapped writes ignored", pulses, 1);

    // R2: random reference, noisy periodic stream, random arming
    phase = "R2";
    for (int r = 0; r < 6; r++) begin
      int pat [WIN];
      for (int i = 0; i < WIN; i++) begin
        pat[i] = 100 + $urandom_range(3800);
        wr(i, pat[i]);
      end
      wr(WIN, 60 + $urandom_range(300));
      idle(10);
      step(1, 0, 0);
      for (int k = 0; k < 220; k++) begin
        bit a = ($urandom_range(63) == 0);
        bit v = ($urandom_range(9) < 8);
        int s = pat[k % WIN] + $urandom_range(4) - 2;
        step(a, v, s);
      end
      idle(10);
    end

    summary();
    $finish;
  end
endmodule